// File: doc/BRIEF.md
# Save Memory Unlock Gate

This block sits between a console CPU bus and a small non-volatile save memory, such as a battery-backed SRAM or a ferroelectric RAM. It watches each physical bus address and the write data for a write to a control register in the I/O bank. Bit 7 of that write sets or clears a latched unlock state. While the block is unlocked, it enables the memory for bus cycles that fall in a 2 KB window of a fixed save bank. While it is locked, the memory stays deselected, so its data pins stay tri-stated and software that never touches the save memory sees no change.

The physical address is 21 bits wide: an 8-bit bank number above a 13-bit offset. The block passes the read and write strobes through to the memory unchanged. If the fitted memory is larger than 2 KB, the block ties its extra upper address lines to a fixed block number. A status LED output shows the unlock state.

Top module: `bram_gate`

## Requirements
- R1: After reset the block is locked: `led` is 0, and `mem_ce_n` is 1 for every bus cycle.
- R2: A write (`cpu_wr_n` low) to offset 0x1803 in bank `IO_BANK` with data bit 7 set unlocks the block. The new state shows on `led` after the next rising clock edge.
- R3: A write to that control register with data bit 7 clear locks the block at the next rising edge.
- R4: A read (`cpu_rd_n` low) of that control register locks the block at the next rising edge.
- R5: A bus cycle at any other address, including offset 0x1803 in another bank, leaves the unlock state unchanged.
- R6: `mem_ce_n` is low only when all three of these hold: the block is unlocked, a strobe is active, and the address lies in bank `SAVE_BANK` at an offset below 0x800. The offset 0x800 itself is outside the window.
- R7: `mem_oe_n` always equals `cpu_rd_n`, and `mem_we_n` always equals `cpu_wr_n`.
- R8: `mem_addr` carries `cpu_addr[10:0]` in its low 11 bits and the parameter `BLK_SEL` in its upper bits.
- R9: `led` is 1 exactly when the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; locks the block |
| cpu_addr | input | 21 | Physical address: bank in the upper 8 bits, offset in the lower 13 |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd_n | input | 1 | Active-low read strobe |
| cpu_wr_n | input | 1 | Active-low write strobe |
| mem_addr | output | MEM_AW | Address to the save memory |
| mem_ce_n | output | 1 | Active-low chip enable to the save memory |
| mem_oe_n | output | 1 | Active-low output enable to the save memory |
| mem_we_n | output | 1 | Active-low write enable to the save memory |
| led | output | 1 | Unlock status indicator |

## Verification
The bench builds the block with `IO_BANK` 0xFF, `SAVE_BANK` 0xF7, a 15-bit memory address and `BLK_SEL` 4'b0101. With a non-zero block number, a wrong split between the block bits and the pass-through bits shows up at the `mem_addr` port. The I/O bank and the save bank differ only in a few bits, and a decoy bank 0xFE sits next to the I/O bank. These choices put a bank compare that misses one bit within reach, as well as the edges of the 2 KB window at offsets 0x7FF and 0x800.

// File: rtl/bram_gate.sv
module bram_gate #(
  parameter int BANK_W = 8,
  parameter int OFS_W = 13,
  parameter logic [BANK_W-1:0] IO_BANK = 8'hFF,
  parameter logic [BANK_W-1:0] SAVE_BANK = 8'hF7,
  parameter logic [OFS_W-1:0] CTRL_OFS = 13'h1803,
  parameter int WIN_AW = 11,
  parameter int MEM_AW = 15,
  parameter logic [MEM_AW-WIN_AW-1:0] BLK_SEL = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BANK_W+OFS_W-1:0]   cpu_addr,
  input  logic [7:0]                cpu_wdata,
  input  logic                      cpu_rd_n,
  input  logic                      cpu_wr_n,
  output logic [MEM_AW-1:0]         mem_addr,
  output logic                      mem_ce_n,
  output logic                      mem_oe_n,
  output logic                      mem_we_n,
  output logic                      led
);
  localparam int AW = BANK_W + OFS_W;

  logic [BANK_W-1:0] bank;
  logic [OFS_W-1:0]  ofs;
  logic              ctrl_hit, in_window, strobe, unlocked;

  assign bank      = cpu_addr[AW-1:OFS_W];
  assign ofs       = cpu_addr[OFS_W-1:0];
  assign ctrl_hit  = (bank == IO_BANK) && (ofs == CTRL_OFS);
  assign in_window = (bank == SAVE_BANK) && (ofs[OFS_W-1:WIN_AW] == '0);
  assign strobe    = !cpu_rd_n || !cpu_wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n)
      unlocked <= 1'b0;
    else if (ctrl_hit && !cpu_wr_n)
      unlocked <= cpu_wdata[7];
    else if (ctrl_hit && !cpu_rd_n)
      unlocked <= 1'b0;
  end

  assign mem_ce_n = !(unlocked && in_window && strobe);
  assign mem_oe_n = cpu_rd_n;
  assign mem_we_n = cpu_wr_n;
  assign mem_addr = {BLK_SEL, cpu_addr[WIN_AW-1:0]};
  assign led      = unlocked;

  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && !cpu_wr_n && cpu_wdata[7]) |=> led);
  p_relock_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && !cpu_wr_n && !cpu_wdata[7]) |=> !led);
  p_relock_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && cpu_wr_n && !cpu_rd_n) |=> !led);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_hit && strobe) |=> $stable(led));
  p_locked_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !led |-> mem_ce_n);
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (bank == SAVE_BANK && strobe));
  p_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n == cpu_rd_n) && (mem_we_n == cpu_wr_n));
endmodule

// File: tb/tb_bram_gate.sv
module tb_bram_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam logic [3:0] BLK = 4'b0101;

  logic clk = 0, rst_n = 0;
  logic [20:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_rd_n = 1, cpu_wr_n = 1;
  logic [14:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, led;
  int checks = 0, failures = 0;

  bram_gate #(.IO_BANK(8'hFF), .SAVE_BANK(8'hF7), .MEM_AW(15), .BLK_SEL(BLK)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .led(led));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {rd_n, wr_n, addr, data, exp_ce_n (before edge), exp_led (after edge)}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 1'b1, 21'h1EE000, 8'h00, 1'b1, 1'b0}, // R6 locked read of window
    {1'b1, 1'b0, 21'h1FF803, 8'h80, 1'b1, 1'b1}, // R2 unlock
    {1'b0, 1'b1, 21'h1EE000, 8'h00, 1'b0, 1'b1}, // R6 read window start
    {1'b1, 1'b0, 21'h1EE7FF, 8'h5A, 1'b0, 1'b1}, // R6 write window end
    {1'b0, 1'b1, 21'h1EE800, 8'h00, 1'b1, 1'b1}, // R6 just past window
    {1'b1, 1'b1, 21'h1EE010, 8'h00, 1'b1, 1'b1}, // R6 no strobe
    {1'b1, 1'b0, 21'h1FD803, 8'h00, 1'b1, 1'b1}, // R5 decoy bank
    {1'b1, 1'b0, 21'h1FF803, 8'h7F, 1'b1, 1'b0}, // R3 relock by write
    {1'b1, 1'b0, 21'h1EE004, 8'h11, 1'b1, 1'b0}, // R6 locked write
    {1'b1, 1'b0, 21'h1FF803, 8'hFF, 1'b1, 1'b1}, // R2 unlock again
    {1'b0, 1'b1, 21'h1FF803, 8'h00, 1'b1, 1'b0}, // R4 relock by read
    {1'b1, 1'b0, 21'h1FF803, 8'h80, 1'b1, 1'b1}, // R2 unlock
    {1'b0, 1'b1, 21'h1EC000, 8'h00, 1'b1, 1'b1}  // R5 R6 other bank
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cpu_addr = 21'h1EE000; cpu_rd_n = 0;
    #1;
    check("R1 led", 32'(led), 0);
    check("R1 ce_n", 32'(mem_ce_n), 1);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cpu_rd_n, cpu_wr_n, cpu_addr, cpu_wdata} = VEC[i][32:2];
      #1;
      check($sformatf("R6 ce_n v%0d", i), 32'(mem_ce_n), 32'(VEC[i][1]));
      check("R7 oe_n", 32'(mem_oe_n), 32'(VEC[i][32]));
      check("R7 we_n", 32'(mem_we_n), 32'(VEC[i][31]));
      check("R8 mem_addr", 32'(mem_addr), 32'({BLK, VEC[i][20:10]}));
      @(negedge clk);
      cpu_rd_n = 1; cpu_wr_n = 1;
      #1;
      check($sformatf("R9 led v%0d", i), 32'(led), 32'(VEC[i][0]));
    end
    // reset while unlocked
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cpu_addr = 21'h1EE123; cpu_wr_n = 0;
    #1;
    check("R1 led after reset", 32'(led), 0);
    check("R1 ce_n after reset", 32'(mem_ce_n), 1);
    cpu_wr_n = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule